// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits behind the host bus pins of a flash array and turns raw write cycles into operation requests. It watches the chip-enable, write-enable, output-enable and address-valid strobes. It builds one write event per completed bus cycle, carrying an address and a data word. It then walks those events through the multi-cycle unlock sequences that guard every state-changing command. When a sequence completes, it emits a single-cycle request that names the operation (word program, sector erase or whole-array erase), the target address and the data.

Two bus write styles are handled. In the strobe-only style, the leading edge of the combined CE/WE strobe captures the address and the trailing edge captures the data. When the synchronous read configuration is selected, the host may also present the address with the address-valid strobe on a rising edge of the bus clock, and that latched address wins over the pins seen at the strobe. A fast-program state lets the host program a word with two writes instead of four. It stays active until the host exits it explicitly. Array programming, erase timing and status reporting are handled elsewhere.

Top module: `fcd_cmd_decoder`

## Requirements
- R1: While `rst` is high and in the cycle after it, `op_valid` is 0; after reset the decoder is in the idle state and not in fast-program mode.
- R2: A write cycle begins when both `ce_n` and `we_n` are low (the later falling edge), capturing `addr` then, and ends when either rises (the first rising edge), capturing `data` then.
- R3: A write cycle during which `oe_n` is sampled low, at its start or at any point up to its end, is discarded and does not advance the sequence.
- R4: With `sync_en` high, a rising `bclk` edge seen while `avd_n` and `ce_n` are low and `oe_n` is high latches `addr`; the next write cycle uses that address instead of the pins. With `sync_en` low, `bclk` and `avd_n` have no effect.
- R5: The writes AAh@555h, 55h@2AAh, A0h@555h and then data D at address A produce one op with `op_kind` 1 (program), `op_addr` A and `op_data` D. Address matching uses the low 12 address bits and data matching uses the low 8 data bits.
- R6: The writes AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh and then 30h at address S produce an op with `op_kind` 2 (sector erase), `op_addr` S and `op_data` 0. Each further 30h write at another address adds one more sector op, until some other write ends the run.
- R7: The same erase prefix ending in 10h@555h produces one op with `op_kind` 3 (whole-array erase), `op_addr` 0 and `op_data` 0.
- R8: AAh@555h, 55h@2AAh, 20h@555h enters fast-program mode. In that mode, A0h at any address followed by data D at address A produces a program op (kind 1, A, D), and the mode is kept after each program.
- R9: In fast-program mode, 90h then 00h returns the decoder to the normal idle state, after which a bare A0h-plus-data pair produces no op.
- R10: Any write that does not match the expected next step returns to the normal idle state with no op. A write with low byte F0h does the same from every state except the data step of a program, where it is taken as program data.
- R11: `op_valid` is high for exactly one cycle per operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Decoder clock; bus pins are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sync_en | input | 1 | 1 selects the synchronous read configuration, enabling address-valid latching |
| bclk | input | 1 | Host bus clock, used only for address-valid latching |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low; must stay high for a valid write |
| avd_n | input | 1 | Address valid, active low |
| addr | input | ADDR_W | Host address pins |
| data | input | DATA_W | Host data pins |
| op_valid | output | 1 | One-cycle request pulse |
| op_kind | output | 2 | 1 program, 2 sector erase, 3 whole-array erase |
| op_addr | output | ADDR_W | Target address of the request |
| op_data | output | DATA_W | Program data, 0 for erases |

## Verification
The reset command byte F0h and the program data capture meet on the same write: when a program's data word carries F0h in its low byte, both the reset rule and the data step apply. The bench provokes this in the normal four-write program and again in fast-program mode. It judges the outcome by expecting a program op that carries F0h as data. In fast-program mode it also expects a following two-write program to still be accepted, which shows the mode was not dropped.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

    localparam int CMD_AW = 12;
    localparam int CMD_DW = 8;

    localparam logic [CMD_AW-1:0] ADR_KEY_A = 12'h555;
    localparam logic [CMD_AW-1:0] ADR_KEY_B = 12'h2AA;

    localparam logic [CMD_DW-1:0] CMD_KEY_A   = 8'hAA;
    localparam logic [CMD_DW-1:0] CMD_KEY_B   = 8'h55;
    localparam logic [CMD_DW-1:0] CMD_PROG    = 8'hA0;
    localparam logic [CMD_DW-1:0] CMD_ERASE   = 8'h80;
    localparam logic [CMD_DW-1:0] CMD_FASTON  = 8'h20;
    localparam logic [CMD_DW-1:0] CMD_SECTOR  = 8'h30;
    localparam logic [CMD_DW-1:0] CMD_WHOLE   = 8'h10;
    localparam logic [CMD_DW-1:0] CMD_FASTOFF = 8'h90;
    localparam logic [CMD_DW-1:0] CMD_CONFIRM = 8'h00;
    localparam logic [CMD_DW-1:0] CMD_RESET   = 8'hF0;

    typedef enum logic [1:0] {
        OP_NONE   = 2'd0,
        OP_PROG   = 2'd1,
        OP_SECTOR = 2'd2,
        OP_WHOLE  = 2'd3
    } op_kind_t;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_KEY1,
        ST_KEY2,
        ST_PDATA,
        ST_ESETUP,
        ST_EKEY1,
        ST_EKEY2,
        ST_EMORE,
        ST_FAST,
        ST_FPDATA,
        ST_FEXIT
    } seq_state_t;

    function automatic logic step_hit(input logic [CMD_AW-1:0] a,
                                      input logic [CMD_DW-1:0] d,
                                      input logic [CMD_AW-1:0] ea,
                                      input logic [CMD_DW-1:0] ed);
        return (a == ea) && (d == ed);
    endfunction

endpackage

// File: rtl/fcd_bus_capture.sv
module fcd_bus_capture #(
    parameter int ADDR_W = 22,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sync_en,
    input  logic              bclk,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              avd_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);

    logic              p_ce_n, p_we_n, p_oe_n, p_avd_n, p_bclk, p_bclk_d;
    logic [ADDR_W-1:0] p_addr;
    logic [DATA_W-1:0] p_data;
    logic              act_d;
    logic              sync_hit;
    logic [ADDR_W-1:0] sync_addr;
    logic [ADDR_W-1:0] cyc_addr;
    logic              oe_ok;

    logic act, cyc_start, cyc_end, bclk_rise, avd_latch;

    always_comb begin
        act       = ~p_ce_n & ~p_we_n;
        cyc_start = act & ~act_d;
        cyc_end   = ~act & act_d;
        bclk_rise = p_bclk & ~p_bclk_d;
        avd_latch = sync_en & bclk_rise & ~p_avd_n & ~p_ce_n & p_oe_n;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            p_ce_n    <= 1'b1;
            p_we_n    <= 1'b1;
            p_oe_n    <= 1'b1;
            p_avd_n   <= 1'b1;
            p_bclk    <= 1'b0;
            p_bclk_d  <= 1'b0;
            p_addr    <= '0;
            p_data    <= '0;
            act_d     <= 1'b0;
            sync_hit  <= 1'b0;
            sync_addr <= '0;
            cyc_addr  <= '0;
            oe_ok     <= 1'b0;
            wr_valid  <= 1'b0;
            wr_addr   <= '0;
            wr_data   <= '0;
        end else begin
            p_ce_n   <= ce_n;
            p_we_n   <= we_n;
            p_oe_n   <= oe_n;
            p_avd_n  <= avd_n;
            p_bclk   <= bclk;
            p_bclk_d <= p_bclk;
            p_addr   <= addr;
            p_data   <= data;
            act_d    <= act;

            if (cyc_end)
                sync_hit <= 1'b0;
            if (avd_latch) begin
                sync_hit  <= 1'b1;
                sync_addr <= p_addr;
            end

            if (cyc_start) begin
                if (avd_latch)
                    cyc_addr <= p_addr;
                else if (sync_en && sync_hit)
                    cyc_addr <= sync_addr;
                else
                    cyc_addr <= p_addr;
                oe_ok <= p_oe_n;
            end else if (act && !p_oe_n) begin
                oe_ok <= 1'b0;
            end

            wr_valid <= cyc_end & oe_ok & p_oe_n;
            if (cyc_end) begin
                wr_addr <= cyc_addr;
                wr_data <= p_data;
            end
        end
    end

    // R3
    oe_gate_chk: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> $past(p_oe_n));

    // R2
    one_event_chk: assert property (@(posedge clk) disable iff (rst)
        wr_valid |=> !wr_valid);

endmodule

// File: rtl/fcd_cmd_seq.sv
module fcd_cmd_seq
    import fcd_pkg::*;
#(
    parameter int ADDR_W = 22,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              op_valid,
    output op_kind_t          op_kind,
    output logic [ADDR_W-1:0] op_addr,
    output logic [DATA_W-1:0] op_data
);

    seq_state_t state, nxt;
    op_kind_t   emit;

    logic [CMD_AW-1:0] la;
    logic [CMD_DW-1:0] ld;
    logic              data_step;

    always_comb begin
        la        = wr_addr[CMD_AW-1:0];
        ld        = wr_data[CMD_DW-1:0];
        data_step = (state == ST_PDATA) || (state == ST_FPDATA);
        nxt       = state;
        emit      = OP_NONE;
        if (wr_valid) begin
            nxt = ST_IDLE;
            unique case (state)
                ST_IDLE:   if (step_hit(la, ld, ADR_KEY_A, CMD_KEY_A)) nxt = ST_KEY1;
                ST_KEY1:   if (step_hit(la, ld, ADR_KEY_B, CMD_KEY_B)) nxt = ST_KEY2;
                ST_KEY2: begin
                    if (step_hit(la, ld, ADR_KEY_A, CMD_PROG))        nxt = ST_PDATA;
                    else if (step_hit(la, ld, ADR_KEY_A, CMD_ERASE))  nxt = ST_ESETUP;
                    else if (step_hit(la, ld, ADR_KEY_A, CMD_FASTON)) nxt = ST_FAST;
                end
                ST_PDATA:  emit = OP_PROG;
                ST_ESETUP: if (step_hit(la, ld, ADR_KEY_A, CMD_KEY_A)) nxt = ST_EKEY1;
                ST_EKEY1:  if (step_hit(la, ld, ADR_KEY_B, CMD_KEY_B)) nxt = ST_EKEY2;
                ST_EKEY2: begin
                    if (step_hit(la, ld, ADR_KEY_A, CMD_WHOLE)) begin
                        emit = OP_WHOLE;
                    end else if (ld == CMD_SECTOR) begin
                        emit = OP_SECTOR;
                        nxt  = ST_EMORE;
                    end
                end
                ST_EMORE: begin
                    if (ld == CMD_SECTOR) begin
                        emit = OP_SECTOR;
                        nxt  = ST_EMORE;
                    end
                end
                ST_FAST: begin
                    if (ld == CMD_PROG)         nxt = ST_FPDATA;
                    else if (ld == CMD_FASTOFF) nxt = ST_FEXIT;
                end
                ST_FPDATA: begin
                    emit = OP_PROG;
                    nxt  = ST_FAST;
                end
                ST_FEXIT:  nxt = ST_IDLE;
                default:   nxt = ST_IDLE;
            endcase
            if (ld == CMD_RESET && !data_step) begin
                nxt  = ST_IDLE;
                emit = OP_NONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            op_valid <= 1'b0;
            op_kind  <= OP_NONE;
            op_addr  <= '0;
            op_data  <= '0;
        end else begin
            state    <= nxt;
            op_valid <= (emit != OP_NONE);
            if (emit != OP_NONE) begin
                op_kind <= emit;
                op_addr <= (emit == OP_WHOLE) ? '0 : wr_addr;
                op_data <= (emit == OP_PROG) ? wr_data : '0;
            end
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> !op_valid);

    // R11
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> !op_valid);

    // R10
    reset_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_data[CMD_DW-1:0] == CMD_RESET &&
         state != ST_PDATA && state != ST_FPDATA) |=> (state == ST_IDLE && !op_valid));

    // R6
    sector_path_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_kind == OP_SECTOR) |-> state == ST_EMORE);

endmodule

// File: rtl/fcd_cmd_decoder.sv
module fcd_cmd_decoder
    import fcd_pkg::*;
#(
    parameter int ADDR_W = 22,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sync_en,
    input  logic              bclk,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              avd_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output logic              op_valid,
    output logic [1:0]        op_kind,
    output logic [ADDR_W-1:0] op_addr,
    output logic [DATA_W-1:0] op_data
);

    logic              wr_valid;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    op_kind_t          kind_w;

    fcd_bus_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_capture (
        .clk(clk), .rst(rst), .sync_en(sync_en), .bclk(bclk),
        .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .avd_n(avd_n),
        .addr(addr), .data(data),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    fcd_cmd_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk(clk), .rst(rst),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .op_valid(op_valid), .op_kind(kind_w),
        .op_addr(op_addr), .op_data(op_data)
    );

    assign op_kind = kind_w;

endmodule

// File: tb/fcd_cmd_decoder_bench.sv
module fcd_cmd_decoder_bench;

    localparam int AW = 22;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sync_en = 1'b0;
    logic          bclk = 1'b0;
    logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, avd_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] data = '0;
    logic          op_valid;
    logic [1:0]    op_kind;
    logic [AW-1:0] op_addr;
    logic [DW-1:0] op_data;

    always #2 clk = ~clk;

    fcd_cmd_decoder #(.ADDR_W(AW), .DATA_W(DW)) u_fcd_cmd_decoder (
        .clk(clk), .rst(rst), .sync_en(sync_en), .bclk(bclk),
        .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .avd_n(avd_n),
        .addr(addr), .data(data),
        .op_valid(op_valid), .op_kind(op_kind), .op_addr(op_addr), .op_data(op_data)
    );

    typedef struct {
        logic [1:0]    kind;
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        string         req;
    } exp_t;

    exp_t exp_q[$];
    int   n_run  = 0;
    int   n_fail = 0;
    bit   done   = 1'b0;

    task automatic tick(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_op(input logic [1:0] k, input logic [AW-1:0] a,
                             input logic [DW-1:0] d, input string req);
        exp_t e;
        e.kind = k; e.a = a; e.d = d; e.req = req;
        exp_q.push_back(e);
    endtask

    // plain WE-controlled write; oe_low drives oe_n low mid-cycle
    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit oe_low = 0);
        addr = a; data = d; ce_n = 1'b0;
        tick();
        we_n = 1'b0;
        tick();
        if (oe_low) oe_n = 1'b0;
        tick();
        oe_n = 1'b1;
        tick();
        we_n = 1'b1;
        tick();
        ce_n = 1'b1; addr = 22'h3FFFFF; data = 16'hFFFF;
        tick(2);
    endtask

    // CE falls last (address taken then), CE rises first (data taken then)
    task automatic wr_ce_late(input logic [AW-1:0] a, input logic [DW-1:0] d);
        we_n = 1'b0; addr = 22'h0ABCD; data = 16'h0000;
        tick();
        addr = a; ce_n = 1'b0;
        tick();
        addr = 22'h0ABCD;
        tick();
        data = d;
        tick();
        ce_n = 1'b1;
        tick();
        data = 16'h5A5A; we_n = 1'b1;
        tick(2);
    endtask

    // address presented with avd_n and a bclk rise, then pins change before WE
    task automatic wr_sync(input logic [AW-1:0] a, input logic [AW-1:0] pin_a,
                           input logic [DW-1:0] d);
        addr = a; avd_n = 1'b0; ce_n = 1'b0;
        tick();
        bclk = 1'b1;
        tick();
        bclk = 1'b0; avd_n = 1'b1; addr = pin_a;
        tick();
        we_n = 1'b0; data = d;
        tick(2);
        we_n = 1'b1;
        tick();
        ce_n = 1'b1;
        tick(2);
    endtask

    task automatic unlock();
        wr(22'h555, 16'h00AA);
        wr(22'h2AA, 16'h0055);
    endtask

    // monitor: pops expectations as ops appear
    always @(negedge clk) begin
        if (!rst && op_valid) begin
            n_run++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL unexpected op: actual kind=%0d addr=%h data=%h expected none",
                         op_kind, op_addr, op_data);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (op_kind !== e.kind || op_addr !== e.a || op_data !== e.d) begin
                    n_fail++;
                    $display("FAIL %s: actual kind=%0d addr=%h data=%h expected kind=%0d addr=%h data=%h",
                             e.req, op_kind, op_addr, op_data, e.kind, e.a, e.d);
                end
            end
        end
    end

    // R11: no two consecutive op cycles
    logic prev_op = 1'b0;
    always @(negedge clk) begin
        if (!rst && op_valid && prev_op) begin
            n_run++; n_fail++;
            $display("FAIL R11: actual op_valid=1 two cycles, expected single pulse");
        end
        prev_op <= op_valid;
    end

    task automatic drain_check(input string req);
        tick(6);
        n_run++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL %s: actual %0d ops missing, expected 0", req, exp_q.size());
            exp_q.delete();
        end
    endtask

    initial begin
        tick(3);
        // R1: quiet during and after reset
        n_run++;
        if (op_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: actual op_valid=%b expected 0", op_valid);
        end
        rst = 1'b0;
        tick(2);
        n_run++;
        if (op_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: actual op_valid=%b expected 0 after reset", op_valid);
        end

        // R5 + R2: four-cycle program, data cycle with CE falling last / rising first
        unlock(); wr(22'h555, 16'h00A0);
        expect_op(2'd1, 22'h12345, 16'hBEEF, "R5/R2 program ce-late");
        wr_ce_late(22'h12345, 16'hBEEF);
        drain_check("R5");

        // R3: data cycle with OE low is ignored; next valid write is the data
        unlock(); wr(22'h555, 16'h00A0);
        wr(22'h01111, 16'h2222, 1);
        expect_op(2'd1, 22'h00777, 16'h1111, "R3 oe-low ignored");
        wr(22'h00777, 16'h1111);
        drain_check("R3");

        // R6: sector erase, two sectors, then reset
        unlock(); wr(22'h555, 16'h0080); unlock();
        expect_op(2'd2, 22'h40000, 16'h0000, "R6 sector first");
        wr(22'h40000, 16'h0030);
        expect_op(2'd2, 22'h48000, 16'h0000, "R6 sector second");
        wr(22'h48000, 16'h0030);
        wr(22'h0, 16'h00F0);
        wr(22'h50000, 16'h0030);
        drain_check("R6");

        // R7: whole-array erase
        unlock(); wr(22'h555, 16'h0080); unlock();
        expect_op(2'd3, 22'h0, 16'h0000, "R7 whole erase");
        wr(22'h555, 16'h0010);
        drain_check("R7");

        // R10: bad third step, then stray program writes produce nothing
        unlock(); wr(22'h555, 16'h0077);
        wr(22'h555, 16'h00A0); wr(22'h00100, 16'h005A);
        // R10: F0 mid-sequence returns to idle
        unlock(); wr(22'h123, 16'h00F0);
        wr(22'h555, 16'h00A0); wr(22'h00200, 16'h006B);
        drain_check("R10 mismatch/reset");
        // R10: F0 as program data is data, not reset
        unlock(); wr(22'h555, 16'h00A0);
        expect_op(2'd1, 22'h02000, 16'h00F0, "R10 F0 as data");
        wr(22'h02000, 16'h00F0);
        drain_check("R10 F0 data");

        // R8: fast-program mode, two-write programs, F0 data keeps the mode
        unlock(); wr(22'h555, 16'h0020);
        wr(22'h0, 16'h00A0);
        expect_op(2'd1, 22'h03000, 16'hCAFE, "R8 fast program");
        wr(22'h03000, 16'hCAFE);
        wr(22'h0, 16'h00A0);
        expect_op(2'd1, 22'h03002, 16'h00F0, "R8/R10 fast F0 data");
        wr(22'h03002, 16'h00F0);
        wr(22'h0, 16'h00A0);
        expect_op(2'd1, 22'h03004, 16'h7777, "R8 mode kept");
        wr(22'h03004, 16'h7777);
        drain_check("R8");

        // R9: exit, then bare program pair is ignored
        wr(22'h0, 16'h0090); wr(22'h0, 16'h0000);
        wr(22'h0, 16'h00A0); wr(22'h04000, 16'h1234);
        // R10: F0 in fast mode also leaves it
        unlock(); wr(22'h555, 16'h0020);
        wr(22'h0, 16'h00F0);
        wr(22'h0, 16'h00A0); wr(22'h04002, 16'h4321);
        drain_check("R9 exit");

        // R4: synchronous address latch wins over pins
        sync_en = 1'b1;
        unlock(); wr(22'h555, 16'h00A0);
        expect_op(2'd1, 22'h15000, 16'h9999, "R4 sync addr");
        wr_sync(22'h15000, 22'h00AAA, 16'h9999);
        drain_check("R4 sync");
        // R4: with sync_en low the bclk/avd latch is ignored
        sync_en = 1'b0;
        unlock(); wr(22'h555, 16'h00A0);
        expect_op(2'd1, 22'h00AAA, 16'h8888, "R4 async ignores avd");
        wr_sync(22'h15000, 22'h00AAA, 16'h8888);
        drain_check("R4 async");

        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule